// File: doc/BRIEF.md
# Dual-Lane Latch-or-Register Bus Path

This block carries one direction of a registered bus transceiver. Two lanes of nine bits travel through it. Each lane holds eight data bits and one parity bit. Every stored bit works in one of three modes. It is transparent while the latch enable is high. It loads on the rising clock edge when the latch enable is low and that lane's active-low clock enable is low. In any other case it keeps its value. An active-low output enable controls whether the stored value is driven onto the far port. High impedance is modelled as a data word paired with a drive flag. The opposite direction uses a second, identical instance.

Each lane has its own mode decoder, which names three modes: FOLLOW, LOAD and KEEP. FOLLOW applies whenever the latch enable is high. LOAD applies when the latch enable is low and the lane's clock enable is low. KEEP applies when the latch enable is low and the lane's clock enable is high. The decoder moves between modes each cycle, purely from the current control inputs. LOAD and FOLLOW both write the storage at the clock edge. KEEP leaves it unchanged. The lane output is the live input in FOLLOW and the stored word otherwise. Latch timing is treated as cycle-based: while the latch enable is high, the storage tracks the input at every edge. When the latch enable falls, the lane therefore holds the word that was present at the last edge with the latch enable high.

Top module: `bus_path_cell`

## Requirements
- R1: An asynchronous active-low reset clears all stored bits to zero. With the latch enable low, `bus_out` then reads zero.
- R2: While `latch_en` is high, `bus_out` equals `bus_in` in the same cycle, with no clock edge needed.
- R3: While `latch_en` is high, each rising edge loads the storage. After `latch_en` falls, `bus_out` shows the `bus_in` value sampled at the last edge where `latch_en` was high.
- R4: With `latch_en` low, a rising edge loads lane k (bits 9k+8 down to 9k) from `bus_in` only when `lane_clk_en_n[k]` is low. Until that edge, the output keeps the old value.
- R5: With `latch_en` low and `lane_clk_en_n[k]` high, lane k's output stays unchanged across clock edges, whatever `bus_in` does.
- R6: The two lanes are independent. One lane can load on an edge while the other keeps its value.
- R7: Bit 8 of each lane (the parity bit, bit positions 8 and 17) is stored and forwarded exactly like a data bit.
- R8: `bus_drive` is the inverse of `out_en_n`, where high means the port is driven. `out_en_n` never alters the stored word or `bus_out`.
- R9: While `latch_en` is high, the lane clock enables have no effect: every lane loads at each edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Storage clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| latch_en | input | 1 | High selects transparent mode for both lanes |
| lane_clk_en_n | input | 2 | Per-lane clock enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| bus_in | input | 18 | Source-port word, lane k at bits 9k+8:9k |
| bus_out | output | 18 | Word presented to the far port |
| bus_drive | output | 1 | High when the far port is driven, low for high impedance |

## Verification
Two events can coincide in one cycle: a lane load on a clock edge and a change of `latch_en`. A second coincidence is one lane loading while the other keeps its value. The bench provokes the first by driving a new input word and lowering the latch enable between two edges. It then judges that the output still shows the word from the last transparent edge, not the newly driven word. It provokes the second by enabling only one lane. It then checks that the bits of the held lane keep their old value, while the bits of the enabled lane take the new word.

// File: rtl/bus_path_pkg.sv
package bus_path_pkg;
    typedef enum logic [1:0] {
        MODE_FOLLOW = 2'd0,
        MODE_LOAD   = 2'd1,
        MODE_KEEP   = 2'd2
    } store_mode_e;
endpackage

// File: rtl/lane_mode_decode.sv
module lane_mode_decode
    import bus_path_pkg::*;
(
    input  logic        latch_en,
    input  logic        clk_en_n,
    output store_mode_e mode
);
    always_comb begin
        unique case ({latch_en, clk_en_n})
            2'b10, 2'b11: mode = MODE_FOLLOW;
            2'b00:        mode = MODE_LOAD;
            default:      mode = MODE_KEEP;
        endcase
    end
endmodule

// File: rtl/lane_store.sv
module lane_store
    import bus_path_pkg::*;
#(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  store_mode_e      mode,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] view
);
    logic [WIDTH-1:0] q;

    // state register: storage word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            unique case (mode)
                MODE_FOLLOW, MODE_LOAD: q <= d;
                default:                q <= q;
            endcase
        end
    end

    // output process: transparent in FOLLOW, stored word otherwise
    always_comb begin
        unique case (mode)
            MODE_FOLLOW: view = d;
            default:     view = q;
        endcase
    end
endmodule

// File: rtl/bus_path_cell.sv
module bus_path_cell
    import bus_path_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LANES  = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           latch_en,
    input  logic [LANES-1:0]               lane_clk_en_n,
    input  logic                           out_en_n,
    input  logic [LANES*(DATA_W+1)-1:0]    bus_in,
    output logic [LANES*(DATA_W+1)-1:0]    bus_out,
    output logic                           bus_drive
);
    localparam int LANE_W = DATA_W + 1;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        store_mode_e mode;

        lane_mode_decode u_dec (
            .latch_en (latch_en),
            .clk_en_n (lane_clk_en_n[k]),
            .mode     (mode)
        );

        lane_store #(.WIDTH(LANE_W)) u_store (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (mode),
            .d     (bus_in[k*LANE_W +: LANE_W]),
            .view  (bus_out[k*LANE_W +: LANE_W])
        );
    end

    assign bus_drive = ~out_en_n;
endmodule

// File: rtl/bus_path_chk.sv
module bus_path_chk #(
    parameter int DATA_W = 8,
    parameter int LANES  = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        latch_en,
    input logic [LANES-1:0]            lane_clk_en_n,
    input logic                        out_en_n,
    input logic [LANES*(DATA_W+1)-1:0] bus_in,
    input logic [LANES*(DATA_W+1)-1:0] bus_out,
    input logic                        bus_drive
);
    localparam int LANE_W = DATA_W + 1;

    // R2
    transparent_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en |-> bus_out == bus_in);

    // R3
    latch_fall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(latch_en) && $past(rst_n)) |-> bus_out == $past(bus_in));

    // R8
    drive_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(out_en_n) |-> bus_drive != $past(bus_drive));

    for (genvar k = 0; k < LANES; k++) begin : g_chk
        // R4
        lane_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!latch_en && !$past(latch_en) && !$past(lane_clk_en_n[k]) && $past(rst_n))
            |-> bus_out[k*LANE_W +: LANE_W] == $past(bus_in[k*LANE_W +: LANE_W]));

        // R5
        lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!latch_en && !$past(latch_en) && $past(lane_clk_en_n[k]) && $past(rst_n))
            |-> $stable(bus_out[k*LANE_W +: LANE_W]));
    end
endmodule

bind bus_path_cell bus_path_chk #(.DATA_W(DATA_W), .LANES(LANES)) u_chk (.*);

// File: tb/tb_bus_path_cell.sv
module tb_bus_path_cell;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        latch_en;
    logic [1:0]  lane_clk_en_n;
    logic        out_en_n;
    logic [17:0] bus_in;
    logic [17:0] bus_out;
    logic        bus_drive;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    bus_path_cell dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .latch_en      (latch_en),
        .lane_clk_en_n (lane_clk_en_n),
        .out_en_n      (out_en_n),
        .bus_in        (bus_in),
        .bus_out       (bus_out),
        .bus_drive     (bus_drive)
    );

    task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; latch_en = 1'b0; lane_clk_en_n = 2'b00;
        out_en_n = 1'b0; bus_in = 18'h2A5C3;
        step(); step();
        chk("R1 reset clears", bus_out, 18'h0);
        rst_n = 1'b1; lane_clk_en_n = 2'b11;
        step();
        chk("R1 zero after release", bus_out, 18'h0);
    endtask

    task automatic t_transparent();
        latch_en = 1'b1; bus_in = 18'h1F00F; #1;
        chk("R2 follow A", bus_out, 18'h1F00F);
        bus_in = 18'h0A1B2; #1;
        chk("R2 follow B", bus_out, 18'h0A1B2);
    endtask

    task automatic t_latch_fall();
        latch_en = 1'b1; lane_clk_en_n = 2'b11; bus_in = 18'h12345;
        step();
        latch_en = 1'b0; bus_in = 18'h3FFFF; #1;
        chk("R3 hold after fall", bus_out, 18'h12345);
        step();
        chk("R3 still held", bus_out, 18'h12345);
    endtask

    task automatic t_capture();
        latch_en = 1'b0; lane_clk_en_n = 2'b00; bus_in = 18'h2BEEF; #1;
        chk("R4 no edge yet", bus_out, 18'h12345);
        step();
        chk("R4 captured", bus_out, 18'h2BEEF);
    endtask

    task automatic t_hold();
        lane_clk_en_n = 2'b11; bus_in = 18'h05555;
        step(); step();
        chk("R5 lanes held", bus_out, 18'h2BEEF);
    endtask

    task automatic t_independent();
        lane_clk_en_n = 2'b10; bus_in = 18'h00000;
        step();
        chk("R6 lane0 loads lane1 keeps", bus_out, {9'h15F, 9'h000});
        lane_clk_en_n = 2'b01; bus_in = 18'h3FFFF;
        step();
        chk("R6 lane1 loads lane0 keeps", bus_out, {9'h1FF, 9'h000});
    endtask

    task automatic t_parity();
        lane_clk_en_n = 2'b00; bus_in = 18'h20100;
        step();
        chk("R7 parity bits only", bus_out, 18'h20100);
        bus_in = 18'h1FEFF;
        step();
        chk("R7 parity bits cleared", bus_out, 18'h1FEFF);
    endtask

    task automatic t_oe();
        lane_clk_en_n = 2'b11; out_en_n = 1'b1; #1;
        chk("R8 released", {17'h0, bus_drive}, 18'h0);
        step();
        chk("R8 data untouched", bus_out, 18'h1FEFF);
        out_en_n = 1'b0; #1;
        chk("R8 driven", {17'h0, bus_drive}, 18'h1);
    endtask

    task automatic t_le_over_cen();
        latch_en = 1'b1; lane_clk_en_n = 2'b11; bus_in = 18'h0C3A5;
        step();
        latch_en = 1'b0; bus_in = 18'h00001; #1;
        chk("R9 loaded despite enables", bus_out, 18'h0C3A5);
    endtask

    initial begin
        t_reset();
        t_transparent();
        t_latch_fall();
        t_capture();
        t_hold();
        t_independent();
        t_parity();
        t_oe();
        t_le_over_cen();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule